// File: doc/BRIEF.md
# Compare-Match Timer Interrupt Source

An eight-bit up-counter moves forward by one on each cycle where a slow tick enable is high and software has set the run bit. When the count reaches the programmed compare value, the counter goes back to zero on that same advance and keeps counting. The timer's period is therefore the compare value plus one tick.

The compare event can latch an interrupt flag, but only while the interrupt enable (mask) bit is set. A level interrupt request line follows the flag, so an interrupt controller can sample it directly. Software clears the flag by writing one to it.

A small register bus reaches the compare value, the run control, the live count, the enable bit and the flag. Writes take effect on a clock edge, and reads return data combinationally from the address.

Top module: `cmt_timer_irq`

## Requirements
- R1: When the counter advances while its value equals the compare value and the enable bit is 1, the flag reads 1 and `irq_req` is high after that clock edge.
- R2: When the enable bit is 0, a compare match leaves the flag at 0 and `irq_req` low.
- R3: Reset puts the registers in a known state. Compare reads 0xFF, run, enable, flag and count read 0, and `irq_req` is low. Asserting `rst_n` clears `irq_req` at once, without waiting for a clock edge.
- R4: `irq_req` equals the stored flag bit at all times.
- R5: Writing a word with bit 0 set to offset 0x4 clears the flag. Writing a word with bit 0 clear to that offset leaves the flag unchanged.
- R6: When a masked-in compare match and a flag-clear write occur in the same cycle, the flag ends up set.
- R7: On a compare match the counter returns to 0 and continues counting, so it steps through 0 up to the compare value.
- R8: The counter changes only on cycles where both `tick_en` and the run bit are 1. Otherwise it holds its value.
- R9: The register map is as follows. Offset 0x0 holds the compare value (read/write). Offset 0x1 holds the run control in bit 0. Offset 0x2 returns the live count (read-only). Offset 0x3 holds the enable in bit 0. Offset 0x4 holds the flag in bit 0. Reads of 0x1, 0x3 and 0x4 return the stored bit in bit 0 and zero in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Slow oscillator tick, one-cycle enable |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Level interrupt request |

## Verification
The assertions assume two things about the inputs. First, `bus_addr` and `bus_wdata` are stable around each sampling edge. Second, a write and a tick can arrive together, because the flag-clear and match-priority properties are written for that case. They do not assume that ticks are spaced out.

The stimulus drives every input on the falling edge and removes it shortly after the rising edge. It holds the address steady while the read data is compared. It deliberately lines a flag-clear write up with a masked-in match to exercise the priority rule.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CMP  = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_RUN  = 3'h1;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_MASK = 3'h3;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 3'h4;
endpackage

// File: rtl/cmt_rst_sync.sv
module cmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    match = adv && (cnt_q == cmp);
    cnt_d = cnt_q;
    if (match)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cmt_irq_flag.sv
module cmt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic mask_en,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic set_evt;

  always_comb begin
    set_evt = match && mask_en;
    flag_d  = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int              CNT_W   = 8,
  parameter int              DATA_W  = 8,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic [CNT_W-1:0]  cmp,
  output logic              run,
  output logic              mask_en,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_BIT = DATA_W - 1;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             run_q, run_d;
  logic             mask_q, mask_d;
  logic             wr_cmp, wr_run, wr_mask, wr_flag;

  always_comb begin
    wr_cmp  = wr_en && (addr == OFS_CMP);
    wr_run  = wr_en && (addr == OFS_RUN);
    wr_mask = wr_en && (addr == OFS_MASK);
    wr_flag = wr_en && (addr == OFS_FLAG);

    cmp_d  = wr_cmp  ? wdata[CNT_W-1:0] : cmp_q;
    run_d  = wr_run  ? wdata[0]         : run_q;
    mask_d = wr_mask ? wdata[0]         : mask_q;
    flag_clr = wr_flag && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= CMP_RST;
      run_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_q  <= cmp_d;
      if (wr_run)  run_q  <= run_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_CMP:  rdata = {{PAD_CNT{1'b0}}, cmp_q};
      OFS_RUN:  rdata = {{PAD_BIT{1'b0}}, run_q};
      OFS_CNT:  rdata = {{PAD_CNT{1'b0}}, cnt};
      OFS_MASK: rdata = {{PAD_BIT{1'b0}}, mask_q};
      OFS_FLAG: rdata = {{PAD_BIT{1'b0}}, flag};
      default:  rdata = '0;
    endcase
  end

  assign cmp     = cmp_q;
  assign run     = run_q;
  assign mask_en = mask_q;
endmodule

// File: rtl/cmt_timer_irq.sv
module cmt_timer_irq
  import cmt_pkg::*;
#(
  parameter int               CNT_W       = 8,
  parameter int               DATA_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_RST     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);
  logic             rst_n_sync;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] cnt_val;
  logic             run_bit;
  logic             mask_bit;
  logic             flag_bit;
  logic             flag_clr;
  logic             adv;
  logic             match;

  cmt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign adv = tick_en && run_bit;

  cmt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CMP_RST(CMP_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_val),
    .flag     (flag_bit),
    .cmp      (cmp_val),
    .run      (run_bit),
    .mask_en  (mask_bit),
    .flag_clr (flag_clr),
    .rdata    (bus_rdata)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv   (adv),
    .cmp   (cmp_val),
    .cnt   (cnt_val),
    .match (match)
  );

  cmt_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .match   (match),
    .mask_en (mask_bit),
    .clr_req (flag_clr),
    .flag    (flag_bit)
  );

  assign irq_req = flag_bit;
endmodule

// File: rtl/cmt_timer_irq_chk.sv
module cmt_timer_irq_chk
  import cmt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              run,
  input logic              mask_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_req
);
  logic step;
  logic hit;
  logic wr_flag;

  assign step    = tick_en && run;
  assign hit     = step && (cnt == cmp);
  assign wr_flag = bus_wr_en && (bus_addr == OFS_FLAG);

  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mask_en) |=> irq_req); // R1
  AST_NO_FLAG_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !mask_en) |=> !irq_req); // R2
  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_FLAG) |-> (bus_rdata[0] == irq_req)); // R4
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && wr_flag && !bus_wdata[0]) |=> irq_req); // R5
  AST_ONE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && bus_wdata[0] && !(hit && mask_en)) |=> !irq_req); // R5
  AST_MATCH_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && bus_wdata[0] && hit && mask_en) |=> irq_req); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == OFS_MASK) || (bus_addr == OFS_FLAG) || (bus_addr == OFS_RUN))
      |-> (bus_rdata[DATA_W-1:1] == '0)); // R9
endmodule

bind cmt_timer_irq cmt_timer_irq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .tick_en   (tick_en),
  .run       (run_bit),
  .mask_en   (mask_bit),
  .cnt       (cnt_val),
  .cmp       (cmp_val),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req)
);

// File: tb/cmt_timer_irq_test.sv
module cmt_timer_irq_test;
  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       bus_wr_en;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmt_timer_irq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // row: we, addr, wdata, tick, check addr, expected read, expected irq, requirement
  localparam int NV = 19;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'h03, 1'b0, 3'd0, 8'h03, 1'b0, 4'd9}, // R9 compare = 3
    {1'b1, 3'd1, 8'h01, 1'b0, 3'd1, 8'h01, 1'b0, 4'd9}, // R9 run on
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h01, 1'b0, 4'd8}, // R8 tick -> 1
    {1'b0, 3'd0, 8'h00, 1'b0, 3'd2, 8'h01, 1'b0, 4'd8}, // R8 no tick holds
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h02, 1'b0, 4'd8},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h03, 1'b0, 4'd7},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h00, 1'b0, 4'd2}, // R2 unmasked match
    {1'b0, 3'd0, 8'h00, 1'b0, 3'd2, 8'h00, 1'b0, 4'd7}, // R7 wrapped
    {1'b1, 3'd3, 8'hFF, 1'b0, 3'd3, 8'h01, 1'b0, 4'd9}, // R9 upper bits zero
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h01, 1'b0, 4'd7},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h02, 1'b0, 4'd7},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h03, 1'b0, 4'd7},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h01, 1'b1, 4'd1}, // R1 masked match
    {1'b0, 3'd0, 8'h00, 1'b0, 3'd2, 8'h00, 1'b1, 4'd7}, // R7 wrap again
    {1'b1, 3'd4, 8'hFE, 1'b0, 3'd4, 8'h01, 1'b1, 4'd5}, // R5 zero write
    {1'b1, 3'd4, 8'h01, 1'b0, 3'd4, 8'h00, 1'b0, 4'd5}, // R5 clear
    {1'b1, 3'd1, 8'h00, 1'b0, 3'd1, 8'h00, 1'b0, 4'd9}, // run off
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h00, 1'b0, 4'd8}, // R8 tick ignored
    {1'b1, 3'd3, 8'h00, 1'b0, 3'd3, 8'h00, 1'b0, 4'd9}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] d,
                       input logic tk);
    @(negedge clk);
    bus_wr_en = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    #2;
    bus_wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    logic [7:0] v;
    tick_en = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R3 reset state
    rd(3'd0, v); chk("R3 cmp", v, 8'hFF);
    rd(3'd1, v); chk("R3 run", v, 8'h00);
    rd(3'd2, v); chk("R3 cnt", v, 8'h00);
    rd(3'd3, v); chk("R3 mask", v, 8'h00);
    rd(3'd4, v); chk("R3 flag", v, 8'h00);
    chk("R3 irq", {7'd0, irq_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] r;
      string tag;
      r = VEC[i];
      cycle(r[28], r[27:25], r[24:17], r[16]);
      rd(r[15:13], v);
      tag = $sformatf("R%0d row %0d", r[3:0], i);
      chk(tag, v, r[12:5]);
      chk({tag, " irq (R4)"}, {7'd0, irq_req}, {7'd0, r[4]});
    end

    // R6 match and clear in the same cycle, compare = 0 so every tick matches
    cycle(1'b1, 3'd0, 8'h00, 1'b0);
    cycle(1'b1, 3'd3, 8'h01, 1'b0);
    cycle(1'b1, 3'd1, 8'h01, 1'b0);
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    chk("R1 match at zero", {7'd0, irq_req}, 8'h01);
    cycle(1'b1, 3'd4, 8'h01, 1'b1);
    chk("R6 match beats clear", {7'd0, irq_req}, 8'h01);
    cycle(1'b1, 3'd4, 8'h01, 1'b0);
    chk("R5 clear after", {7'd0, irq_req}, 8'h00);

    // R3 asynchronous reset while the flag is set
    cycle(1'b0, 3'd0, 8'h00, 1'b1);
    chk("R1 set again", {7'd0, irq_req}, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R3 async irq low", {7'd0, irq_req}, 8'h00);
    rd(3'd3, v); chk("R3 mask after reset", v, 8'h00);
    rd(3'd1, v); chk("R3 run after reset", v, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    rd(3'd0, v); chk("R3 cmp after reset", v, 8'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule